// File: doc/BRIEF.md
# Pair Queue Concentrator

A bank of pair filters produces accepted particle pairs at irregular rates, but the force datapath behind it takes at most one pair per cycle. This block gives every filter a small FIFO of its own and drains the whole bank into one output stream, one pair per cycle. Each output pair is tagged with the index of the FIFO it came from.

Every cycle an arbiter selects one FIFO to pop. A FIFO holding `DEPTH-1` or more entries counts as urgent and wins over any FIFO that merely holds data. Each of the two classes keeps its own rotating pointer, so ties inside a class are settled round-robin. When two or more FIFOs are urgent at once, a registered hold signal tells every filter to stop pushing. The filters must respect that hold for the FIFOs to stay lossless.

Top module: `pair_queue_merge`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` and `hold` are low.
- R2: Every pushed item leaves `out_data` exactly once. Items from one source leave in the order they were pushed. `out_src` gives the index of the source FIFO (0 to `NUM_SRC-1`).
- R3: At most one FIFO is popped per clock edge. The popped item appears on the outputs one cycle later. `out_valid` is high exactly when some FIFO held data at the edge where the selection was made.
- R4: A FIFO is urgent when its occupancy is at least `DEPTH-1`. If any FIFO is urgent, the popped FIFO is an urgent one.
- R5: Among urgent FIFOs the choice rotates. Under sustained load on every source, the per-source grant counts differ by at most `DEPTH`.
- R6: When no FIFO is urgent, the search starts at the non-urgent class pointer and goes upward with wrap-around. The first non-empty FIFO found is popped. That pointer moves to the granted index plus one (wrapping) only when this class wins. After reset both pointers are 0.
- R7: `hold` is high on the cycle after an edge at which more than one FIFO was urgent, and low otherwise.
- R8: If no source pushes while `hold` is high, no FIFO ever holds more than `DEPTH` items, and no push lands on a full FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | NUM_SRC | Per-source push strobe |
| push_data | input | NUM_SRC*DATA_W | Per-source push payload, source i in bits [i*DATA_W +: DATA_W] |
| hold | output | 1 | Registered request for all sources to stop pushing |
| out_valid | output | 1 | Output item present this cycle |
| out_data | output | DATA_W | Output payload |
| out_src | output | SRC_W | Index of the FIFO that supplied the item |

## Verification
The bench keeps its own occupancy count for each FIFO. Every cycle it checks that the granted source was an urgent one whenever any FIFO was urgent; an arbiter that ignored the urgent class would let a queue overflow, and this check catches it before that happens. It checks that `hold` follows the count of urgent queues with exactly one cycle of lag, so a throttle that comes a cycle late or never comes shows up directly. A short directed sequence checks the exact grant order of the non-urgent rotation, including wrap-around past the last index, which catches a pointer that fails to advance or advances on the other class's wins. Long random bursts and a saturated phase catch lost or reordered items and starvation by fixed priority.

// File: rtl/pqm_pkg.sv
package pqm_pkg;

    typedef enum logic [1:0] {
        CLS_IDLE   = 2'd0,
        CLS_URGENT = 2'd1,
        CLS_READY  = 2'd2
    } grant_cls_e;

    // Index one past idx, wrapping to 0 after n-1.
    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/pqm_fifo.sv
module pqm_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              nonempty,
    output logic              near_full,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.mem[s_q.wr_ptr] = wr_data;
            s_d.wr_ptr          = ptr_inc(s_q.wr_ptr);
        end
        if (rd_en) begin
            s_d.rd_ptr = ptr_inc(s_q.rd_ptr);
        end
        s_d.cnt = s_q.cnt + CNT_W'(wr_en) - CNT_W'(rd_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data   = s_q.mem[s_q.rd_ptr];
    assign nonempty  = (s_q.cnt != '0);
    assign near_full = (s_q.cnt >= CNT_W'(DEPTH - 1));
    assign full      = (s_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/pqm_rr_pick.sv
module pqm_rr_pick #(
    parameter int N     = 9,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        int cand;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            cand = int'(start) + k;
            if (cand >= N) cand = cand - N;
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/pair_queue_merge.sv
module pair_queue_merge #(
    parameter int NUM_SRC = 9,
    parameter int DEPTH   = 8,
    parameter int DATA_W  = 16,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        push_valid,
    input  logic [NUM_SRC*DATA_W-1:0] push_data,
    output logic                      hold,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data,
    output logic [SRC_W-1:0]          out_src
);
    import pqm_pkg::*;

    typedef struct packed {
        logic [SRC_W-1:0]  urg_ptr;
        logic [SRC_W-1:0]  rdy_ptr;
        logic              hold;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
        logic [SRC_W-1:0]  out_src;
    } merge_state_t;

    merge_state_t st_d, st_q;

    logic [NUM_SRC-1:0] q_nonempty;
    logic [NUM_SRC-1:0] q_near_full;
    logic [NUM_SRC-1:0] q_full;
    logic [NUM_SRC-1:0] pop_vec;
    logic [DATA_W-1:0]  q_head [NUM_SRC];

    logic               urg_found, rdy_found;
    logic [SRC_W-1:0]   urg_idx, rdy_idx;
    logic [SRC_W-1:0]   grant_idx;
    grant_cls_e         grant_cls;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_q
        pqm_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (push_valid[g]),
            .wr_data   (push_data[g*DATA_W +: DATA_W]),
            .rd_en     (pop_vec[g]),
            .rd_data   (q_head[g]),
            .nonempty  (q_nonempty[g]),
            .near_full (q_near_full[g]),
            .full      (q_full[g])
        );
    end

    pqm_rr_pick #(.N(NUM_SRC), .IDX_W(SRC_W)) u_pick_urgent (
        .req   (q_near_full),
        .start (st_q.urg_ptr),
        .found (urg_found),
        .idx   (urg_idx)
    );

    pqm_rr_pick #(.N(NUM_SRC), .IDX_W(SRC_W)) u_pick_ready (
        .req   (q_nonempty),
        .start (st_q.rdy_ptr),
        .found (rdy_found),
        .idx   (rdy_idx)
    );

    // Class selection: urgent class first, then any non-empty queue.
    always_comb begin
        if (urg_found) begin
            grant_cls = CLS_URGENT;
            grant_idx = urg_idx;
        end else if (rdy_found) begin
            grant_cls = CLS_READY;
            grant_idx = rdy_idx;
        end else begin
            grant_cls = CLS_IDLE;
            grant_idx = '0;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            pop_vec[i] = (grant_cls != CLS_IDLE) && (grant_idx == SRC_W'(i));
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.hold      = ($countones(q_near_full) > 1);
        st_d.out_valid = (grant_cls != CLS_IDLE);
        st_d.out_src   = grant_idx;
        st_d.out_data  = (grant_cls != CLS_IDLE) ? q_head[grant_idx] : '0;
        if (grant_cls == CLS_URGENT) begin
            st_d.urg_ptr = SRC_W'(wrap_next(int'(grant_idx), NUM_SRC));
        end
        if (grant_cls == CLS_READY) begin
            st_d.rdy_ptr = SRC_W'(wrap_next(int'(grant_idx), NUM_SRC));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold      = st_q.hold;
    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
    assign out_src   = st_q.out_src;

endmodule

// File: rtl/pqm_chk.sv
module pqm_chk #(
    parameter int NUM_SRC = 9,
    parameter int SRC_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] push_valid,
    input logic [NUM_SRC-1:0] q_full,
    input logic [NUM_SRC-1:0] q_near_full,
    input logic [NUM_SRC-1:0] q_nonempty,
    input logic [NUM_SRC-1:0] pop_vec,
    input logic               hold,
    input logic               out_valid,
    input logic [SRC_W-1:0]   out_src
);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid & q_full) == '0);

    // R3
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));

    // R3
    valid_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_nonempty != '0) |=> out_valid);

    // R3
    idle_follows_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_nonempty == '0) |=> !out_valid);

    // R4
    urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_near_full != '0) |-> ((pop_vec & q_near_full) != '0));

    // R7
    hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(q_near_full) > 1) |=> hold);

    // R7
    hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(q_near_full) <= 1) |=> !hold);

    // R2
    src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_src) < NUM_SRC));

endmodule

bind pair_queue_merge pqm_chk #(
    .NUM_SRC (NUM_SRC),
    .SRC_W   (SRC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .q_full      (q_full),
    .q_near_full (q_near_full),
    .q_nonempty  (q_nonempty),
    .pop_vec     (pop_vec),
    .hold        (hold),
    .out_valid   (out_valid),
    .out_src     (out_src)
);

// File: tb/sim_pair_queue_merge.sv
module sim_pair_queue_merge;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC    = 9;
    localparam int DEPTH      = 8;
    localparam int DATA_W     = 16;
    localparam int SRC_W      = $clog2(NUM_SRC);

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NUM_SRC-1:0]        push_valid = '0;
    logic [NUM_SRC*DATA_W-1:0] push_data = '0;
    logic                      hold;
    logic                      out_valid;
    logic [DATA_W-1:0]         out_data;
    logic [SRC_W-1:0]          out_src;

    pair_queue_merge #(
        .NUM_SRC (NUM_SRC),
        .DEPTH   (DEPTH),
        .DATA_W  (DATA_W)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_data  (push_data),
        .hold       (hold),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_src    (out_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [DATA_W-1:0] exp_q [NUM_SRC][$];
    int                occ [NUM_SRC];
    int                seq [NUM_SRC];
    int                gcount [NUM_SRC];
    int                glog [$];
    logic [NUM_SRC-1:0] applied_push;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of pushes (respecting hold) and record expected items.
    task automatic drive_cycle(input logic [NUM_SRC-1:0] want);
        logic [NUM_SRC-1:0] v;
        v = hold ? '0 : want;
        for (int i = 0; i < NUM_SRC; i++) begin
            logic [DATA_W-1:0] item;
            item = {4'(i), 12'(seq[i])};
            push_data[i*DATA_W +: DATA_W] = item;
            if (v[i]) begin
                exp_q[i].push_back(item);
                seq[i]++;
            end
        end
        push_valid = v;
        @(negedge clk);
        push_valid = '0;
    endtask

    always @(posedge clk) applied_push <= rst_n ? push_valid : '0;

    // Monitor: scoreboard plus occupancy model.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) occ[i] = 0;
        end else begin
            int nf;
            int any;
            nf = 0;
            any = 0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (occ[i] >= DEPTH - 1) nf++;
                if (occ[i] > 0) any = 1;
            end
            // R3: valid iff some queue held data at the selecting edge
            chk(out_valid == (any != 0), "R3", "out_valid vs occupancy", int'(out_valid), any);
            // R7: hold follows the urgent count with one cycle of lag
            chk(hold == (nf > 1), "R7", "hold vs urgent count", int'(hold), int'(nf > 1));
            if (out_valid) begin
                int s;
                s = int'(out_src);
                glog.push_back(s);
                gcount[s]++;
                // R4: urgent queue granted when one exists
                if (nf > 0)
                    chk(occ[s] >= DEPTH - 1, "R4", "granted occupancy", occ[s], DEPTH - 1);
                // R2: data order and source tag
                if (exp_q[s].size() == 0) begin
                    chk(1'b0, "R2", "unexpected item from source", s, -1);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q[s].pop_front();
                    chk(out_data == e, "R2", "item data", int'(out_data), int'(e));
                end
                occ[s]--;
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                if (applied_push[i]) occ[i]++;
                // R8: occupancy bounded
                if (occ[i] > DEPTH)
                    chk(1'b0, "R8", "occupancy exceeds depth", occ[i], DEPTH);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_SRC; i++) begin
            seq[i] = 0;
            gcount[i] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs low during reset
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(hold == 1'b0, "R1", "hold in reset", int'(hold), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(hold == 1'b0, "R1", "hold after reset", int'(hold), 0);

        // R6: rotation order from pointer 0: sources 7,3,1 pushed together
        glog.delete();
        drive_cycle(NUM_SRC'(9'b010001010));
        repeat (6) @(negedge clk);
        chk(glog.size() == 3, "R6", "grant count", glog.size(), 3);
        if (glog.size() == 3) begin
            chk(glog[0] == 1, "R6", "first grant", glog[0], 1);
            chk(glog[1] == 3, "R6", "second grant", glog[1], 3);
            chk(glog[2] == 7, "R6", "third grant", glog[2], 7);
        end
        // R6: pointer now past 7, search wraps: 0 then 1
        glog.delete();
        drive_cycle(NUM_SRC'(9'b000000011));
        repeat (5) @(negedge clk);
        chk(glog.size() == 2, "R6", "wrap grant count", glog.size(), 2);
        if (glog.size() == 2) begin
            chk(glog[0] == 0, "R6", "wrap first grant", glog[0], 0);
            chk(glog[1] == 1, "R6", "wrap second grant", glog[1], 1);
        end

        // R2/R4/R7/R8: random bursty traffic
        begin
            int burst [NUM_SRC];
            for (int i = 0; i < NUM_SRC; i++) burst[i] = 0;
            for (int c = 0; c < 4000; c++) begin
                logic [NUM_SRC-1:0] w;
                w = '0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (burst[i] == 0 && $urandom_range(0, 15) == 0)
                        burst[i] = $urandom_range(1, 12);
                    if (burst[i] > 0) begin
                        w[i] = ($urandom_range(0, 3) != 0);
                        burst[i]--;
                    end
                end
                drive_cycle(w);
            end
        end
        repeat (100) @(negedge clk);
        for (int i = 0; i < NUM_SRC; i++)
            chk(exp_q[i].size() == 0, "R2", "items left after drain", exp_q[i].size(), 0);

        // R5: fairness under saturation of all sources
        for (int i = 0; i < NUM_SRC; i++) gcount[i] = 0;
        for (int c = 0; c < 2000; c++) drive_cycle('1);
        begin
            int mn, mx;
            mn = gcount[0];
            mx = gcount[0];
            for (int i = 1; i < NUM_SRC; i++) begin
                if (gcount[i] < mn) mn = gcount[i];
                if (gcount[i] > mx) mx = gcount[i];
            end
            chk(mx - mn <= DEPTH, "R5", "grant spread under saturation", mx - mn, DEPTH);
            chk(mn > 0, "R5", "minimum grants", mn, 1);
        end
        repeat (100) @(negedge clk);
        for (int i = 0; i < NUM_SRC; i++)
            chk(exp_q[i].size() == 0, "R2", "items left after saturation", exp_q[i].size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule